// File: doc/BRIEF.md
# Interrupt Source Steering Router

This block sits between the peripheral interrupt lines and the three agents that can act on them: the DMA channels, a data-transfer engine and the CPU interrupt path. Every source has a pending flag. A request line sets the flag, and the flag stays set until the agent that took the request returns a clear. Each pending source is routed to exactly one agent. A DMA channel that is set up to claim a source takes that source for itself. An unclaimed source goes to the transfer engine when its per-source enable bit is set, and to the CPU when the bit is clear. Because of this order, DMA and the transfer engine always have precedence over the CPU.

The transfer engine reports each completed transfer with the source number and two flags. One flag means the transfer counter has run out. The other means the descriptor asks for a CPU interrupt after this transfer. When either flag is set, the block clears that source's enable bit and leaves the source pending, so the request passes to the CPU on the next cycle. Software programs the channel controls and the enable mask through a simple write port.

Top module: `irq_steer_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every pending flag, channel control and enable bit is zero, and `dma_act`, `xfer_act` and `cpu_irq` are all low.
- R2: The channel control word is at address `ch` (0 to NUM_CH-1). Bits [4:0] select the source, bits [6:5] hold the mode, bit 7 is the channel enable and bit 8 is the claim bit. A channel claims its selected source only when mode is 2'b10, the enable bit is 1 and the claim bit is 1. `dma_act[ch]` is high when channel `ch` claims and owns a source that is pending.
- R3: A source that any channel claims never raises `xfer_act` or `cpu_irq`.
- R4: The enable mask is at address NUM_CH, with bit s belonging to source s. A pending, unclaimed source drives `xfer_act[s]` when its bit is 1 and `cpu_irq[s]` when its bit is 0.
- R5: When several claiming channels select the same source, only the lowest-numbered of them raises `dma_act`.
- R6: Each pending source is presented to exactly one consumer. A source that is not pending is presented to none.
- R7: A high `src_req[s]` sets pending flag s at the next edge, and the flag then holds. A `cpu_clr[s]` pulse removes the flag at the next edge. A clear in the same cycle as a request wins.
- R8: A done report with the last or mark flag set clears enable bit `xfer_done_src` at the next edge and keeps the source pending, so it moves to the CPU. A done report with neither flag set clears that source's pending flag instead.
- R9: A register write takes effect at the next edge. A hardware clear from R8 wins over a software write to the same enable bit in the same cycle.
- R10: A pulse on `dma_clr[ch]` clears the pending flag of the source selected by channel `ch` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Level request from each peripheral source |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address: channels, then enable mask |
| cfg_wdata | input | DATA_W | Register write data |
| dma_clr | input | NUM_CH | Per-channel clear returned by the DMA controller |
| cpu_clr | input | NUM_SRC | Per-source clear returned by the CPU path |
| xfer_done_valid | input | 1 | Transfer engine reports a finished transfer |
| xfer_done_src | input | SEL_W | Source number of the finished transfer |
| xfer_done_last | input | 1 | Transfer counter reached zero |
| xfer_done_mark | input | 1 | Descriptor asks for a CPU interrupt after this transfer |
| dma_act | output | NUM_CH | DMA channel activation request |
| xfer_act | output | NUM_SRC | Transfer engine activation per source |
| cpu_irq | output | NUM_SRC | CPU interrupt request per source |

## Verification
The bench builds the block with its default parameters: 32 sources, 4 channels and a 5-bit select. With these values every select code maps to a real source and the enable mask fills the whole write word. The random channel writes pick their selects from a small set of sources, so two or more claiming channels often land on the same source and the lowest-channel ownership rule gets exercised. Done reports, clears and writes are drawn at random, so hardware and software updates to the same enable bit often fall in the same cycle.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam logic [1:0] MODE_CLAIM = 2'b10;

    typedef struct packed {
        logic       claim;
        logic       en;
        logic [1:0] mode;
    } chan_ctl_t;

    function automatic logic ctl_claims(input chan_ctl_t c);
        return (c.mode == MODE_CLAIM) && c.en && c.claim;
    endfunction

endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CH  = 4,
    parameter int SEL_W   = 5,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic [NUM_SRC-1:0]               hw_dis,
    output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
    output chan_ctl_t [NUM_CH-1:0]           ctl_o,
    output logic [NUM_SRC-1:0]               xen_o
);

    localparam int MODE_LSB  = SEL_W;
    localparam int EN_BIT    = SEL_W + 2;
    localparam int CLAIM_BIT = SEL_W + 3;

    typedef struct packed {
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
        chan_ctl_t [NUM_CH-1:0]       ctl;
        logic [NUM_SRC-1:0]           xen;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (cfg_wr && (cfg_addr == ADDR_W'(ch))) begin
                st_d.sel[ch]       = cfg_wdata[SEL_W-1:0];
                st_d.ctl[ch].mode  = cfg_wdata[MODE_LSB+1:MODE_LSB];
                st_d.ctl[ch].en    = cfg_wdata[EN_BIT];
                st_d.ctl[ch].claim = cfg_wdata[CLAIM_BIT];
            end
        end
        if (cfg_wr && (cfg_addr == ADDR_W'(NUM_CH))) begin
            st_d.xen = cfg_wdata[NUM_SRC-1:0];
        end
        // hardware handover beats a same-cycle software write
        st_d.xen = st_d.xen & ~hw_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;
    assign ctl_o = st_q.ctl;
    assign xen_o = st_q.xen;

endmodule

// File: rtl/irq_steer_claim.sv
module irq_steer_claim
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CH  = 4,
    parameter int SEL_W   = 5
) (
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel,
    input  chan_ctl_t [NUM_CH-1:0]       ctl,
    output logic [NUM_CH-1:0]            chan_win,
    output logic [NUM_SRC-1:0]           claim_mask
);

    always_comb begin
        claim_mask = '0;
        chan_win   = '0;
        // ascending scan: the first claiming channel on a source owns it
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ctl_claims(ctl[ch])) begin
                chan_win[ch]          = !claim_mask[sel[ch]];
                claim_mask[sel[ch]]   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_steer_pend.sv
module irq_steer_pend #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags | req) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.flags;

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CH  = 4,
    localparam int SEL_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = $clog2(NUM_CH + 1),
    localparam int DATA_W = (NUM_SRC > SEL_W + 4) ? NUM_SRC : SEL_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [NUM_CH-1:0]  dma_clr,
    input  logic [NUM_SRC-1:0] cpu_clr,
    input  logic               xfer_done_valid,
    input  logic [SEL_W-1:0]   xfer_done_src,
    input  logic               xfer_done_last,
    input  logic               xfer_done_mark,
    output logic [NUM_CH-1:0]  dma_act,
    output logic [NUM_SRC-1:0] xfer_act,
    output logic [NUM_SRC-1:0] cpu_irq
);

    logic [NUM_CH-1:0][SEL_W-1:0] sel_w;
    chan_ctl_t [NUM_CH-1:0]       ctl_w;
    logic [NUM_SRC-1:0]           xen_w;
    logic [NUM_CH-1:0]            win_w;
    logic [NUM_SRC-1:0]           claim_w;
    logic [NUM_SRC-1:0]           pend_w;
    logic [NUM_SRC-1:0]           clr_w;
    logic [NUM_SRC-1:0]           hw_dis_w;

    always_comb begin
        clr_w    = cpu_clr;
        hw_dis_w = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (dma_clr[ch]) clr_w[sel_w[ch]] = 1'b1;
        end
        if (xfer_done_valid) begin
            if (xfer_done_last || xfer_done_mark) hw_dis_w[xfer_done_src] = 1'b1;
            else                                  clr_w[xfer_done_src]    = 1'b1;
        end
    end

    irq_steer_regs #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SEL_W(SEL_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hw_dis    (hw_dis_w),
        .sel_o     (sel_w),
        .ctl_o     (ctl_w),
        .xen_o     (xen_w)
    );

    irq_steer_claim #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
    ) u_claim (
        .sel        (sel_w),
        .ctl        (ctl_w),
        .chan_win   (win_w),
        .claim_mask (claim_w)
    );

    irq_steer_pend #(
        .NUM_SRC(NUM_SRC)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (src_req),
        .clr   (clr_w),
        .pend  (pend_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dma
        assign dma_act[ch] = win_w[ch] & pend_w[sel_w[ch]];
    end

    assign xfer_act = pend_w & ~claim_w &  xen_w;
    assign cpu_irq  = pend_w & ~claim_w & ~xen_w;

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CH  = 4,
    parameter int SEL_W   = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SRC-1:0]           src_req,
    input logic [NUM_SRC-1:0]           cpu_clr,
    input logic                         xfer_done_valid,
    input logic [SEL_W-1:0]             xfer_done_src,
    input logic                         xfer_done_last,
    input logic                         xfer_done_mark,
    input logic [NUM_CH-1:0]            dma_act,
    input logic [NUM_SRC-1:0]           xfer_act,
    input logic [NUM_SRC-1:0]           cpu_irq,
    input logic [NUM_SRC-1:0]           claim_mask,
    input logic [NUM_CH-1:0][SEL_W-1:0] sel
);

    logic [NUM_SRC-1:0] done_oh;
    logic [NUM_SRC-1:0] clr_only;
    assign done_oh  = NUM_SRC'(1) << xfer_done_src;
    assign clr_only = cpu_clr & ~src_req;

    // R3: DMA-claimed sources reach neither other consumer
    a_r3_claim_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_mask & (xfer_act | cpu_irq)) == '0);

    // R6: a source is never presented to both engine and CPU
    a_r6_one_consumer: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act & cpu_irq) == '0);

    // R7: a clear with no new request drops the CPU request next cycle
    a_r7_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_only != '0) |=> ((cpu_irq & $past(clr_only)) == '0));

    // R8: a handover report stops the engine activation for that source
    a_r8_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_valid && (xfer_done_last || xfer_done_mark))
        |=> ((xfer_act & $past(done_oh)) == '0));

    // R5: two channels on one source never both activate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_i
        for (genvar j = i + 1; j < NUM_CH; j++) begin : g_j
            a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
                !(dma_act[i] && dma_act[j] && (sel[i] == sel[j])));
        end
    end

endmodule

bind irq_steer_router irq_steer_chk #(
    .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_req         (src_req),
    .cpu_clr         (cpu_clr),
    .xfer_done_valid (xfer_done_valid),
    .xfer_done_src   (xfer_done_src),
    .xfer_done_last  (xfer_done_last),
    .xfer_done_mark  (xfer_done_mark),
    .dma_act         (dma_act),
    .xfer_act        (xfer_act),
    .cpu_irq         (cpu_irq),
    .claim_mask      (claim_w),
    .sel             (sel_w)
);

// File: tb/irq_steer_router_test.sv
`timescale 1ns/1ps
module irq_steer_router_test;

    localparam int NS = 32;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NC-1:0] dma_clr = '0;
    logic [NS-1:0] cpu_clr = '0;
    logic          xfer_done_valid = 1'b0;
    logic [4:0]    xfer_done_src = '0;
    logic          xfer_done_last = 1'b0;
    logic          xfer_done_mark = 1'b0;
    logic [NC-1:0] dma_act;
    logic [NS-1:0] xfer_act;
    logic [NS-1:0] cpu_irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // reference state
    bit [NS-1:0] m_pend, m_xen;
    int          m_sel[NC];
    int          m_mode[NC];
    bit          m_en[NC], m_claim[NC];

    always #5 clk = ~clk;

    irq_steer_router uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dma_clr(dma_clr), .cpu_clr(cpu_clr),
        .xfer_done_valid(xfer_done_valid), .xfer_done_src(xfer_done_src),
        .xfer_done_last(xfer_done_last), .xfer_done_mark(xfer_done_mark),
        .dma_act(dma_act), .xfer_act(xfer_act), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit claims(input int ch);
        return (m_mode[ch] == 2) && m_en[ch] && m_claim[ch];
    endfunction

    task automatic compare();
        logic [NC-1:0] e_dma = '0;
        logic [NS-1:0] taken = '0;
        logic [NS-1:0] e_x, e_c;
        int bad = 0;
        for (int ch = 0; ch < NC; ch++) begin
            if (claims(ch)) begin
                bit lower = 0;
                for (int k = 0; k < ch; k++)
                    if (claims(k) && m_sel[k] == m_sel[ch]) lower = 1;
                taken[m_sel[ch]] = 1'b1;
                if (!lower && m_pend[m_sel[ch]]) e_dma[ch] = 1'b1;
            end
        end
        e_x = m_pend & ~taken & m_xen;
        e_c = m_pend & ~taken & ~m_xen;
        check("R2/R5 dma_act", 32'(dma_act), 32'(e_dma));
        check("R3/R4 xfer_act", xfer_act, e_x);
        check("R3/R4 cpu_irq", cpu_irq, e_c);
        // R6: count consumers per source from the outputs
        for (int s = 0; s < NS; s++) begin
            int n = int'(xfer_act[s]) + int'(cpu_irq[s]);
            for (int ch = 0; ch < NC; ch++)
                if (dma_act[ch] && m_sel[ch] == s) n++;
            if (n != (m_pend[s] ? 1 : 0)) bad++;
        end
        check("R6 consumers", 32'(bad), 32'd0);
    endtask

    // one clock: compare, advance model with the driven inputs, step
    task automatic step();
        bit [NS-1:0] clr, n_xen;
        compare();
        clr   = cpu_clr;
        n_xen = m_xen;
        for (int ch = 0; ch < NC; ch++) if (dma_clr[ch]) clr[m_sel[ch]] = 1;   // R10
        if (xfer_done_valid && !(xfer_done_last || xfer_done_mark)) clr[xfer_done_src] = 1;
        if (cfg_wr && cfg_addr == 3'd4) n_xen = cfg_wdata;
        if (xfer_done_valid && (xfer_done_last || xfer_done_mark)) n_xen[xfer_done_src] = 0; // R8/R9
        @(posedge clk);
        if (cfg_wr && cfg_addr < 3'd4) begin
            m_sel[cfg_addr]   = int'(cfg_wdata[4:0]);
            m_mode[cfg_addr]  = int'(cfg_wdata[6:5]);
            m_en[cfg_addr]    = cfg_wdata[7];
            m_claim[cfg_addr] = cfg_wdata[8];
        end
        m_pend = (m_pend | src_req) & ~clr;   // R7
        m_xen  = n_xen;
        @(negedge clk);
    endtask

    task automatic idle();
        src_req = '0; cfg_wr = 0; dma_clr = '0; cpu_clr = '0;
        xfer_done_valid = 0; xfer_done_last = 0; xfer_done_mark = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = d;
    endtask

    function automatic logic [31:0] chw(input int sel, input int mode, input bit en, input bit cl);
        return {23'd0, cl, en, 2'(mode), 5'(sel)};
    endfunction

    task automatic randomize_inputs();
        idle();
        src_req = $urandom & $urandom & $urandom;
        if ($urandom_range(0, 7) == 0) cpu_clr = $urandom;
        if ($urandom_range(0, 5) == 0) dma_clr = 4'($urandom);
        if ($urandom_range(0, 3) == 0) begin
            xfer_done_valid = 1;
            xfer_done_src   = 5'($urandom_range(0, 7));
            xfer_done_last  = ($urandom_range(0, 3) == 0);
            xfer_done_mark  = ($urandom_range(0, 3) == 0);
        end
        if ($urandom_range(0, 5) == 0) begin
            int a = $urandom_range(0, 4);
            if (a == 4) wr(4, $urandom);
            else wr(a, chw($urandom_range(0, 5),
                           ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 2,
                           $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0));
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        m_pend = '0; m_xen = '0;
        for (int ch = 0; ch < NC; ch++) begin
            m_sel[ch] = 0; m_mode[ch] = 0; m_en[ch] = 0; m_claim[ch] = 0;
        end
        src_req = '1;                       // requests during reset must not latch
        repeat (3) @(negedge clk);
        check("R1 reset dma_act", 32'(dma_act), 32'd0);
        check("R1 reset cpu_irq", cpu_irq, 32'd0);
        rst_n = 1;
        idle();
        compare();                          // R1 first cycle after reset

        // R4: CPU path, then engine path via enable mask
        src_req = 32'h0000_0011; step();
        idle(); step();
        idle(); wr(4, 32'h0000_0010); step();
        idle(); step();

        // R2/R5: channels 0 and 2 both claim source 4; channel 1 wrong mode
        wr(0, chw(4, 2, 1, 1)); step();
        wr(2, chw(4, 2, 1, 1)); step();
        wr(1, chw(0, 1, 1, 1)); step();
        idle(); step();
        // R10: clear via channel 0 clears source 4
        dma_clr = 4'b0001; step();
        idle(); step();
        // R7: clear beats simultaneous request on source 0
        src_req = 32'h1; cpu_clr = 32'h1; step();
        idle(); step();

        // R8/R9: mark report on source 4 with same-cycle write of all ones
        wr(0, 32'd0); step();
        wr(2, 32'd0); step();
        idle(); src_req = 32'h10; step();
        idle(); wr(4, 32'hFFFF_FFFF);
        xfer_done_valid = 1; xfer_done_src = 5'd4; xfer_done_mark = 1; step();
        idle(); step();
        // R8: plain report on source 5 drops its pending flag
        src_req = 32'h20; step();
        idle(); xfer_done_valid = 1; xfer_done_src = 5'd5; step();
        idle(); step();

        for (int i = 0; i < 4000; i++) begin
            randomize_inputs();
            step();
        end
        idle(); step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule